// File: doc/BRIEF.md
# Counter-Guarded Software-Pipeline Loop Controller

This unit lets a software-pipelined loop run as a single repeated body, with no separate fill or drain code. Each operation group of the loop body has a retiming value. When the loop is launched, the unit loads a bank of signed down-counters, one for each possible retiming value. Groups that share a retiming value therefore share a counter. The counter for retiming value r starts at the loop's largest retiming value minus r.

Every iteration strobe moves all counters down by one. A group is allowed to execute on an iteration only while its counter lies in the window from zero down to, but not including, minus the original trip count n. The iterations where that window is still closed form the fill phase, and the iterations after it closes again form the drain phase. The loop body is strobed n plus the largest retiming value times. The unit then raises a done flag and forces all enables low until the next launch.

Top module: `pcg_loop_guard`

## Requirements
- R1: While reset is held and right after it is released, `en_o`, `busy_o` and `done_o` are all zero.
- R2: A `start_i` pulse captures `trip_i` (n) and `ret_i` and sets `busy_o` in the next cycle. On the first strobe after a launch with n ≥ 1, exactly the groups whose retiming value equals the largest one are enabled.
- R3: Group g's retiming value is in `ret_i[g*RET_W +: RET_W]`. On the j-th strobe of a run (j counted from 0), bit g of `en_o` is high exactly when 0 ≤ r(g) + j − max r < n. A cycle without a strobe leaves the enables unchanged.
- R4: Two groups with equal retiming values always show identical enables.
- R5: Over one complete run, every group is enabled on exactly n strobes.
- R6: After the (n + max r)-th strobe, `done_o` is 1, `busy_o` is 0 and `en_o` is 0 from the next cycle on.
- R7: Before the first launch and after done, `en_o` is 0. Strobes in those states change neither `en_o` nor `done_o`.
- R8: A `start_i` pulse during a run discards that run and starts a new one from the new inputs.
- R9: A launch with n = 0 goes straight to done. No group is ever enabled in that case.
- R10: When `start_i` and `iter_i` arrive in the same cycle, the launch takes effect and the strobe is dropped.
- R11: Changes to `trip_i` and `ret_i` after the launch cycle have no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle launch pulse; loads the counters |
| iter_i | input | 1 | Single-cycle loop iteration strobe |
| trip_i | input | TRIP_W | Original trip count n, sampled at launch |
| ret_i | input | GROUPS*RET_W | Retiming value of each group, group g at bits g*RET_W |
| en_o | output | GROUPS | Per-group execute enable for the current iteration |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The last run has finished |

## Verification
The assertions assume that `start_i` and `iter_i` are sampled only at clock edges. They also assume that the smallest retiming value of a loop is the natural zero point of the schedule: the drain length is counted from the counter that starts at the largest retiming value. The stimulus therefore changes inputs only between edges. It sweeps retiming vectors that include repeated, all-equal and zero-spread sets, and trip counts from 0 up to the full field. It deliberately scrambles `trip_i` and `ret_i` after every launch. This exercises R11 without making the assertions depend on stable inputs.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_RUN  = 2'd1,
    PG_DONE = 2'd2
  } pg_state_e;

  // Open when the counter is in (-trip, 0]
  function automatic logic win_hit(input int p, input int trip);
    return (p <= 0) && (p > -trip);
  endfunction

  // Launch value of the counter that serves retiming value r
  function automatic int preload(input int top, input int r);
    return top - r;
  endfunction

endpackage

// File: rtl/pcg_ret_max.sv
module pcg_ret_max #(
  parameter int GROUPS = 5,
  parameter int RET_W  = 3
) (
  input  logic [GROUPS*RET_W-1:0] ret_i,
  output logic [RET_W-1:0]        top_o
);

  always_comb begin
    top_o = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (ret_i[g*RET_W +: RET_W] > top_o) top_o = ret_i[g*RET_W +: RET_W];
    end
  end

endmodule

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
  import pcg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic iter_i,
  input  logic empty_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic run_o,
  output logic done_o
);

  pg_state_e st_q, st_d;

  assign load_o = start_i;
  assign step_o = iter_i && !start_i && (st_q == PG_RUN);
  assign run_o  = (st_q == PG_RUN);
  assign done_o = (st_q == PG_DONE);

  always_comb begin
    st_d = st_q;
    if (start_i)                st_d = empty_i ? PG_DONE : PG_RUN;
    else if (step_o && last_i)  st_d = PG_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PG_IDLE;
    else        st_q <= st_d;
  end

  // R7: done persists until a new launch
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o);

  // R6: done only rises from a final strobe or an empty launch
  p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(start_i && empty_i) || $past(step_o && last_i)));

  // R9: empty launch lands in done
  p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && empty_i |=> done_o && !run_o);

  // R8: any non-empty launch (also mid-run) starts a run
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !empty_i |=> run_o);

endmodule

// File: rtl/pcg_counter_bank.sv
module pcg_counter_bank
  import pcg_pkg::*;
#(
  parameter int RET_W = 3,
  parameter int CW    = 9,
  localparam int NCNT = 1 << RET_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  logic [RET_W-1:0]    top_i,
  output logic [NCNT*CW-1:0]  cnt_o
);

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    logic signed [CW-1:0] c_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      c_q <= CW'(preload(0, k));
      else if (load_i) c_q <= CW'(preload(int'(top_i), k));
      else if (step_i) c_q <= c_q - CW'(1);
    end

    assign cnt_o[k*CW +: CW] = c_q;

    if (k > 0) begin : g_spacing
      // R4: neighbouring retiming values stay exactly one count apart
      p_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'($signed(cnt_o[(k-1)*CW +: CW])) - int'(c_q)) == 1);
    end
  end

endmodule

// File: rtl/pcg_enable_map.sv
module pcg_enable_map
  import pcg_pkg::*;
#(
  parameter int GROUPS = 5,
  parameter int RET_W  = 3,
  parameter int TRIP_W = 6,
  parameter int CW     = 9,
  localparam int NCNT  = 1 << RET_W
) (
  input  logic                    run_i,
  input  logic [GROUPS*RET_W-1:0] ret_i,
  input  logic [TRIP_W-1:0]       trip_i,
  input  logic [NCNT*CW-1:0]      cnt_i,
  output logic [GROUPS-1:0]       en_o
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [RET_W-1:0]     sel;
    logic signed [CW-1:0] p;

    assign sel     = ret_i[g*RET_W +: RET_W];
    assign p       = cnt_i[int'(sel)*CW +: CW];
    assign en_o[g] = run_i && win_hit(int'(p), int'(trip_i));
  end

endmodule

// File: rtl/pcg_loop_guard.sv
module pcg_loop_guard
  import pcg_pkg::*;
#(
  parameter int GROUPS = 5,
  parameter int RET_W  = 3,
  parameter int TRIP_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    iter_i,
  input  logic [TRIP_W-1:0]       trip_i,
  input  logic [GROUPS*RET_W-1:0] ret_i,
  output logic [GROUPS-1:0]       en_o,
  output logic                    busy_o,
  output logic                    done_o
);

  localparam int NCNT = 1 << RET_W;
  localparam int MAXW = (RET_W > TRIP_W) ? RET_W : TRIP_W;
  localparam int CW   = MAXW + 3;

  logic [RET_W-1:0]        top_w;
  logic [GROUPS*RET_W-1:0] ret_q;
  logic [TRIP_W-1:0]       trip_q;
  logic                    load_w, step_w, run_w, last_w, empty_w;
  logic [NCNT*CW-1:0]      cnt_w;
  logic signed [CW-1:0]    lead_w;

  pcg_ret_max #(.GROUPS(GROUPS), .RET_W(RET_W)) u_max (
    .ret_i (ret_i),
    .top_o (top_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q  <= '0;
      trip_q <= '0;
    end else if (load_w) begin
      ret_q  <= ret_i;
      trip_q <= trip_i;
    end
  end

  // Counter 0 starts highest and is the last to leave its window
  assign lead_w  = cnt_w[CW-1:0];
  assign empty_w = (trip_i == '0);
  assign last_w  = (int'(lead_w) - 1) == -int'(trip_q);

  pcg_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .iter_i  (iter_i),
    .empty_i (empty_w),
    .last_i  (last_w),
    .load_o  (load_w),
    .step_o  (step_w),
    .run_o   (run_w),
    .done_o  (done_o)
  );

  pcg_counter_bank #(.RET_W(RET_W), .CW(CW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_w),
    .step_i (step_w),
    .top_i  (top_w),
    .cnt_o  (cnt_w)
  );

  pcg_enable_map #(.GROUPS(GROUPS), .RET_W(RET_W), .TRIP_W(TRIP_W), .CW(CW)) u_map (
    .run_i  (run_w),
    .ret_i  (ret_q),
    .trip_i (trip_q),
    .cnt_i  (cnt_w),
    .en_o   (en_o)
  );

  assign busy_o = run_w;

  // R2: after a launch the lead counter holds the largest retiming value
  p_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_w && !empty_w |=> int'(lead_w) == int'($past(top_w)));

  // R3: an accepted strobe lowers the lead counter by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |=> int'(lead_w) == int'($past(lead_w)) - 1);

  // R6: a running loop never has its lead counter at or past -n
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> int'(lead_w) > -int'(trip_q));

  // R7: no enable outside a run
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> en_o == '0);

  // R4: equal retiming implies equal enables
  for (genvar a = 0; a < GROUPS; a++) begin : g_pa
    for (genvar b = a + 1; b < GROUPS; b++) begin : g_pb
      p_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_q[a*RET_W +: RET_W] == ret_q[b*RET_W +: RET_W]) |-> (en_o[a] == en_o[b]));
    end
  end

endmodule

// File: tb/test_pcg_loop_guard.sv
module test_pcg_loop_guard;

  localparam int G  = 5;
  localparam int RW = 3;
  localparam int TW = 6;

  logic          clk   = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          iter  = 1'b0;
  logic [TW-1:0] trip  = '0;
  logic [G*RW-1:0] ret = '0;
  logic [G-1:0]  en;
  logic          busy, done;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pcg_loop_guard #(.GROUPS(G), .RET_W(RW), .TRIP_W(TW)) i_pcg_loop_guard (
    .clk (clk), .rst_n (rst_n), .start_i (start), .iter_i (iter),
    .trip_i (trip), .ret_i (ret), .en_o (en), .busy_o (busy), .done_o (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  function automatic logic [G*RW-1:0] pk(input int a, input int b, input int c, input int d, input int e);
    return {RW'(e), RW'(d), RW'(c), RW'(b), RW'(a)};
  endfunction

  function automatic int maxof(input logic [G*RW-1:0] rv);
    int m = 0;
    for (int g = 0; g < G; g++) if (int'(rv[g*RW +: RW]) > m) m = int'(rv[g*RW +: RW]);
    return m;
  endfunction

  // Offset of strobe j into group g's active stretch; active for 0..n-1
  function automatic logic [G-1:0] expect_en(input logic [G*RW-1:0] rv, input int n, input int j);
    logic [G-1:0] e;
    int mx = maxof(rv);
    for (int g = 0; g < G; g++) begin
      int off = int'(rv[g*RW +: RW]) + j - mx;
      e[g] = (off >= 0) && (off < n);
    end
    return e;
  endfunction

  task automatic run_cfg(input logic [G*RW-1:0] rv, input int n, input bit restart);
    int mx = maxof(rv);
    int cnt [G];
    logic [G-1:0] e;
    for (int g = 0; g < G; g++) cnt[g] = 0;
    @(negedge clk); start = 1'b1; ret = rv; trip = TW'(n); iter = 1'b0;
    @(negedge clk); start = 1'b0; ret = ~rv; trip = TW'(n) ^ 6'h2A;   // R11 scramble
    #1;
    if (n == 0) begin
      chk(done && !busy && en == '0, "R9", int'({done, busy, en}), 64);
      return;
    end
    chk(busy && !done, "R2", int'({busy, done}), 2);
    for (int j = 0; j < n + mx; j++) begin
      iter = 1'b1;
      #1;
      e = expect_en(rv, n, j);
      chk(en == e, (j == 0) ? (restart ? "R8" : "R2") : "R3", int'(en), int'(e));
      if (rv[RW +: RW] == rv[2*RW +: RW]) chk(en[1] == en[2], "R4", int'(en[1]), int'(en[2]));
      if (j == n + mx - 1) chk(!done && busy, "R11", int'(done), 0);
      for (int g = 0; g < G; g++) cnt[g] += int'(en[g]);
      @(negedge clk); iter = 1'b0;
      if ((j % 2) == 0 && j + 1 < n + mx) begin
        #1;
        e = expect_en(rv, n, j + 1);
        chk(en == e, "R3", int'(en), int'(e));
        @(negedge clk);
      end
    end
    #1;
    chk(done && !busy && en == '0, "R6", int'({done, busy, en}), 64);
    for (int g = 0; g < G; g++) chk(cnt[g] == n, "R5", cnt[g], n);
    iter = 1'b1;
    @(negedge clk); iter = 1'b0;
    #1;
    chk(done && en == '0, "R7", int'({done, en}), 32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [G*RW-1:0] vecs [6];
    int trips [5];
    vecs[0] = pk(3, 2, 2, 1, 0);
    vecs[1] = pk(0, 0, 0, 0, 0);
    vecs[2] = pk(0, 1, 2, 3, 4);
    vecs[3] = pk(7, 3, 3, 0, 7);
    vecs[4] = pk(5, 5, 5, 5, 5);
    vecs[5] = pk(1, 6, 2, 0, 4);
    trips[0] = 0; trips[1] = 1; trips[2] = 2; trips[3] = 3; trips[4] = 5;

    repeat (3) @(negedge clk);
    #1 chk(en == '0 && !busy && !done, "R1", int'({done, busy, en}), 0);
    @(negedge clk); rst_n = 1'b1;
    #1 chk(en == '0 && !busy && !done, "R1", int'({done, busy, en}), 0);

    // R7: strobes before any launch are ignored
    @(negedge clk); iter = 1'b1;
    @(negedge clk); iter = 1'b0;
    #1 chk(en == '0 && !busy && !done, "R7", int'({done, busy, en}), 0);

    for (int v = 0; v < 6; v++)
      for (int t = 0; t < 5; t++)
        run_cfg(vecs[v], trips[t], 1'b0);
    run_cfg(vecs[3], 63, 1'b0);

    // R8: relaunch in the middle of a run
    @(negedge clk); start = 1'b1; ret = vecs[2]; trip = 6'd4;
    @(negedge clk); start = 1'b0;
    iter = 1'b1; @(negedge clk); iter = 1'b1; @(negedge clk); iter = 1'b0;
    run_cfg(vecs[5], 3, 1'b1);

    // R10: launch and strobe together, strobe is dropped
    @(negedge clk); start = 1'b1; iter = 1'b1; ret = vecs[0]; trip = 6'd2;
    @(negedge clk); start = 1'b0; iter = 1'b0;
    #1 chk(en == 5'b00001 && busy, "R10", int'(en), 1);
    run_cfg(vecs[0], 4, 1'b1);

    summary();
    $finish;
  end

endmodule